// File: doc/BRIEF.md
# TDM Serial Audio Data Port

This block moves one mono audio sample per frame in each direction over a shared serial audio data line. The bit clock and the frame start are supplied from outside as single-cycle strobes in the system clock domain: `bclk_rise` and `bclk_fall` mark the two edges of the serial bit clock, and `frame_start`, given together with a `bclk_rise`, marks bit clock 0 of a new frame. The port counts bit clocks from the frame start. From the frame format, the sample width and a programmable start offset it works out where the left and right data windows lie.

The outgoing sample is sent most significant bit first in the left window only. When tri-state mode is enabled, the output enable is high only while the port is sending its own bits. Several ports with different start offsets can therefore share one line in time-division fashion. The incoming line is captured from the left window, the right window, or both (averaged), according to a 2-bit select. The result is presented in parallel, MSB-aligned, with a one-cycle valid strobe.

Slot convention: the data for slot `k` is launched on the bit-clock fall that follows rise number `k` of the frame. It is captured on the next bit-clock rise, which may be rise 0 of the following frame.

Top module: `tdm_audio_port`

## Requirements
- R1: While `rst_n` is low, and after it until the first frame, `sdo` is 0, `rx_valid` is 0 and `rx_data` is 0. `sdo_oe` is 0 when `hiz_en` is 1 and is 1 when `hiz_en` is 0.
- R2: Data is serialized MSB first. The width code `wsel` selects 16 (00), 20 (01), 24 (10) or 32 (11) bits, taken from the top bits of the 32-bit sample.
- R3: The format code `fmt` sets the base slot of the left window. Left-justified (00) uses base 0. Right-justified (01) uses base HALF_BCLKS − width. I2S (10) uses base 1. DSP (11) uses base 0. The right window begins HALF_BCLKS slots after the left window, except in DSP, where it begins directly after the last left bit.
- R4: A `frame_start` given together with `bclk_rise` makes that rise number 0 of a new frame. Slot `k` is driven after fall `k` and sampled at the following rise.
- R5: `start_ofs` is added to the base slot of both windows, which moves the data start within the frame.
- R6: Transmit data appears only in the left window. Outside it `sdo` is 0. `sdo_oe` is 1 inside the window, and outside it equals the inverse of `hiz_en`.
- R7: `sdo` and `sdo_oe` change only in the clock cycle after a `bclk_fall` strobe. `sdi` is sampled only on `bclk_rise` strobes.
- R8: `rx_sel` chooses the capture: 00 none, 01 left window, 10 right window, 11 the floor of the signed mean of the left and right samples.
- R9: `rx_data` is MSB-aligned with the bits below the width zero. `rx_valid` is high for exactly one clock, in the cycle after the rise that samples the final LSB. `rx_data` holds otherwise.
- R10: Bit-clock strobes seen before the first `frame_start` after reset cause no output drive and no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_rise | input | 1 | Bit-clock rising-edge strobe |
| bclk_fall | input | 1 | Bit-clock falling-edge strobe |
| frame_start | input | 1 | Frame start, valid with bclk_rise |
| fmt | input | 2 | Frame format code |
| wsel | input | 2 | Sample width code |
| start_ofs | input | OFS_W | Data start offset in bit clocks |
| rx_sel | input | 2 | Receive slot select |
| hiz_en | input | 1 | Tri-state outside own window |
| tx_sample | input | 32 | Parallel sample to send, MSB-aligned |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| rx_data | output | 32 | Received sample, MSB-aligned |
| rx_valid | output | 1 | One-cycle strobe for rx_data |

## Verification
On every cycle the embedded assertions check several properties. The left and right windows never coincide. A frame start always rewinds the bit counter. The serial output moves only after a fall strobe and is 0 while not driven. The received word holds between valid pulses, and a valid pulse never appears with capture disabled. Which slot carries which bit for each format, width and offset can only be shown by the bench's frames. The same holds for the averaged capture of negative samples, capture of a last bit that falls in the next frame, and the tri-state pattern across the frame.

// File: rtl/tap_pkg.sv
// Shared types and helpers for the TDM serial audio port.
// Assumes samples are carried MSB-aligned in a 32-bit word.
package tap_pkg;

    localparam int SAMPLE_W = 32;

    typedef enum logic [1:0] {
        FMT_LJ  = 2'b00,
        FMT_RJ  = 2'b01,
        FMT_I2S = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        RXS_OFF   = 2'b00,
        RXS_LEFT  = 2'b01,
        RXS_RIGHT = 2'b10,
        RXS_MIX   = 2'b11
    } rxsel_e;

    // Decode the width code into a bit count.
    function automatic logic [5:0] width_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 6'd16;
            2'b01:   return 6'd20;
            2'b10:   return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/tap_slot_timer.sv
// Bit-clock counter and window decoder.
// Counts bit-clock rises since the last frame start. It decodes whether the
// current slot lies in the left or right data window and which bit of the
// sample it carries. Assumes HALF_BCLKS >= 32 so the windows cannot overlap.
module tap_slot_timer
    import tap_pkg::*;
#(
    parameter int CNT_W      = 9,
    parameter int OFS_W      = 8,
    parameter int HALF_BCLKS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_rise,
    input  logic             frame_start,
    input  logic [1:0]       fmt,
    input  logic [1:0]       wsel,
    input  logic [OFS_W-1:0] start_ofs,
    output logic             left_hit,
    output logic             right_hit,
    output logic [4:0]       bitnum,
    output logic             last_bit
);

    localparam int PW = CNT_W + 1;
    localparam logic [PW-1:0] HALF_P = PW'(HALF_BCLKS);

    logic [CNT_W-1:0] idx_q;
    logic             active_q;

    logic [PW-1:0] idx_p, len_p, base_p, ls_p, le_p, rs_p, re_p;
    logic [PW-1:0] dl_p, dr_p, dsel_p;

    // Count bit-clock rises; a frame start rewinds to slot 0 and arms the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            active_q <= 1'b0;
        end else if (bclk_rise) begin
            if (frame_start) begin
                idx_q    <= '0;
                active_q <= 1'b1;
            end else if (idx_q != {CNT_W{1'b1}}) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Compute window bounds from format, width and offset.
    always_comb begin
        idx_p = {1'b0, idx_q};
        len_p = PW'(width_bits(wsel));
        case (fmt_e'(fmt))
            FMT_RJ:  base_p = HALF_P - len_p;
            FMT_I2S: base_p = PW'(1);
            default: base_p = '0;
        endcase
        ls_p = base_p + PW'(start_ofs);
        le_p = ls_p + len_p;
        rs_p = (fmt_e'(fmt) == FMT_DSP) ? le_p : (ls_p + HALF_P);
        re_p = rs_p + len_p;
    end

    // Decode slot membership and bit position within the window.
    always_comb begin
        left_hit  = active_q && (idx_p >= ls_p) && (idx_p < le_p);
        right_hit = active_q && (idx_p >= rs_p) && (idx_p < re_p);
        dl_p      = idx_p - ls_p;
        dr_p      = idx_p - rs_p;
        dsel_p    = left_hit ? dl_p : dr_p;
        bitnum    = dsel_p[4:0];
        last_bit  = (dsel_p == (len_p - PW'(1)));
    end

    // R3: the two windows never claim the same slot.
    a_r3_slot_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({left_hit, right_hit}));

    // R4: a frame start always rewinds to slot 0 and arms the port.
    a_r4_frame_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_rise && frame_start) |=> (idx_q == '0) && active_q);

endmodule

// File: rtl/tap_tx_serializer.sv
// Transmit serializer.
// Loads the parallel sample on the first bit of the left window and sends it
// MSB first, one bit per bit-clock fall. Drives 0 outside the window. The
// enable follows the window when tri-state mode is on, else stays high.
module tap_tx_serializer
    import tap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_fall,
    input  logic                left_hit,
    input  logic [4:0]          bitnum,
    input  logic                hiz_en,
    input  logic [SAMPLE_W-1:0] tx_sample,
    output logic                sdo,
    output logic                sdo_oe
);

    logic [SAMPLE_W-1:0] sh_q;
    logic                sdo_q;
    logic                drive_q;

    // Launch the next bit on each fall inside the left window, else idle low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            sdo_q   <= 1'b0;
            drive_q <= 1'b0;
        end else if (bclk_fall) begin
            if (left_hit) begin
                drive_q <= 1'b1;
                if (bitnum == 5'd0) begin
                    sdo_q <= tx_sample[SAMPLE_W-1];
                    sh_q  <= tx_sample << 1;
                end else begin
                    sdo_q <= sh_q[SAMPLE_W-1];
                    sh_q  <= sh_q << 1;
                end
            end else begin
                drive_q <= 1'b0;
                sdo_q   <= 1'b0;
            end
        end
    end

    // Output enable: window-gated in tri-state mode, constant otherwise.
    always_comb begin
        sdo    = sdo_q;
        sdo_oe = hiz_en ? drive_q : 1'b1;
    end

    // R7: the line only moves in the cycle after a fall strobe.
    a_r7_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_fall |=> $stable(sdo_q) && $stable(drive_q));

    // R6: when not driving its window the line is held low.
    a_r6_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_q |-> !sdo_q);

endmodule

// File: rtl/tap_rx_deserializer.sv
// Receive deserializer.
// Samples the serial input on bit-clock rises inside the selected window(s),
// builds an MSB-aligned word and publishes it with a one-cycle strobe after
// the last bit. In mix mode the left word is held and averaged with the right.
module tap_rx_deserializer
    import tap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_rise,
    input  logic                left_hit,
    input  logic                right_hit,
    input  logic [4:0]          bitnum,
    input  logic                last_bit,
    input  logic [1:0]          rx_sel,
    input  logic                sdi,
    output logic [SAMPLE_W-1:0] rx_data,
    output logic                rx_valid
);

    logic [SAMPLE_W-1:0] acc_q, lhold_q, data_q, word_now;
    logic                valid_q;
    logic                take_l, take_r;
    logic signed [SAMPLE_W:0] sum;

    // Decide which windows are captured and form the word including this bit.
    always_comb begin
        take_l   = left_hit  && (rx_sel == RXS_LEFT  || rx_sel == RXS_MIX);
        take_r   = right_hit && (rx_sel == RXS_RIGHT || rx_sel == RXS_MIX);
        word_now = (bitnum == 5'd0)
                 ? {sdi, {(SAMPLE_W-1){1'b0}}}
                 : (acc_q | ({{(SAMPLE_W-1){1'b0}}, sdi} << (5'd31 - bitnum)));
        sum      = $signed({lhold_q[SAMPLE_W-1], lhold_q})
                 + $signed({word_now[SAMPLE_W-1], word_now});
    end

    // Accumulate bits and publish finished samples with a single-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            lhold_q <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (bclk_rise && (take_l || take_r)) begin
                acc_q <= word_now;
                if (last_bit) begin
                    if (take_l && rx_sel == RXS_MIX) begin
                        lhold_q <= word_now;
                    end else if (take_l) begin
                        data_q  <= word_now;
                        valid_q <= 1'b1;
                    end else if (rx_sel == RXS_MIX) begin
                        data_q  <= sum[SAMPLE_W:1];
                        valid_q <= 1'b1;
                    end else begin
                        data_q  <= word_now;
                        valid_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign rx_data  = data_q;
    assign rx_valid = valid_q;

    // R9: the strobe lasts one clock.
    a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R9: the published word holds between strobes.
    a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data));

    // R8: nothing is published while capture is off.
    a_r8_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(rx_sel) != RXS_OFF);

endmodule

// File: rtl/tdm_audio_port.sv
// TDM serial audio data port, top level.
// Connects the slot timer to the transmit serializer and receive
// deserializer. Assumes the strobes are synchronous to clk, that a rise and
// a fall are never given in the same cycle, and that configuration only
// changes between a frame's rise 0 and its first fall.
module tdm_audio_port
    import tap_pkg::*;
#(
    parameter int CNT_W      = 9,
    parameter int OFS_W      = 8,
    parameter int HALF_BCLKS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_rise,
    input  logic                bclk_fall,
    input  logic                frame_start,
    input  logic [1:0]          fmt,
    input  logic [1:0]          wsel,
    input  logic [OFS_W-1:0]    start_ofs,
    input  logic [1:0]          rx_sel,
    input  logic                hiz_en,
    input  logic [SAMPLE_W-1:0] tx_sample,
    input  logic                sdi,
    output logic                sdo,
    output logic                sdo_oe,
    output logic [SAMPLE_W-1:0] rx_data,
    output logic                rx_valid
);

    logic       left_hit, right_hit, last_bit;
    logic [4:0] bitnum;

    tap_slot_timer #(
        .CNT_W      (CNT_W),
        .OFS_W      (OFS_W),
        .HALF_BCLKS (HALF_BCLKS)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_rise   (bclk_rise),
        .frame_start (frame_start),
        .fmt         (fmt),
        .wsel        (wsel),
        .start_ofs   (start_ofs),
        .left_hit    (left_hit),
        .right_hit   (right_hit),
        .bitnum      (bitnum),
        .last_bit    (last_bit)
    );

    tap_tx_serializer u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_fall (bclk_fall),
        .left_hit  (left_hit),
        .bitnum    (bitnum),
        .hiz_en    (hiz_en),
        .tx_sample (tx_sample),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    tap_rx_deserializer u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_rise (bclk_rise),
        .left_hit  (left_hit),
        .right_hit (right_hit),
        .bitnum    (bitnum),
        .last_bit  (last_bit),
        .rx_sel    (rx_sel),
        .sdi       (sdi),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );

endmodule

// File: tb/test_tdm_audio_port.sv
`timescale 1ns/1ps
module test_tdm_audio_port;

    localparam int HALF = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_rise = 1'b0, bclk_fall = 1'b0, frame_start = 1'b0;
    logic [1:0]  fmt = 2'b00, wsel = 2'b00, rx_sel = 2'b00;
    logic [7:0]  start_ofs = 8'd0;
    logic        hiz_en = 1'b1;
    logic [31:0] tx_sample = 32'd0;
    logic        sdi = 1'b0;
    logic        sdo, sdo_oe, rx_valid;
    logic [31:0] rx_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit prev_hit = 1'b0;
    logic [31:0] sb_q[$];

    always #4 clk = ~clk;

    tdm_audio_port #(.CNT_W(9), .OFS_W(8), .HALF_BCLKS(HALF)) i_tdm_audio_port (
        .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .frame_start(frame_start), .fmt(fmt), .wsel(wsel), .start_ofs(start_ofs),
        .rx_sel(rx_sel), .hiz_en(hiz_en), .tx_sample(tx_sample), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .rx_data(rx_data), .rx_valid(rx_valid)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: each valid strobe pops one expected word (R8, R9).
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R8 unexpected rx_valid", rx_data, 0);
            end else begin
                logic [31:0] e;
                e = sb_q.pop_front();
                check(rx_data == e, "R9 rx_data", rx_data, e);
            end
        end
    end

    function automatic int wlen(input logic [1:0] c);
        case (c) 2'b00: return 16; 2'b01: return 20; 2'b10: return 24; default: return 32; endcase
    endfunction

    // Driver: one frame of n bit clocks with the given setup; pushes expectations.
    task automatic run_frame(input logic [1:0] f, input logic [1:0] w, input int ofs,
                             input logic [1:0] sel, input bit hz, input logic [31:0] tx,
                             input logic [31:0] lv, input logic [31:0] rv, input int n,
                             input string tag);
        int len, base, ls, rs, vp, err_x, err_t;
        logic [31:0] mask, lm, rm;
        logic signed [32:0] s;
        bit din[512];
        bit e_sdo[512];
        bit e_oe[512];
        len  = wlen(w);
        base = (f == 2'b01) ? HALF - len : (f == 2'b10) ? 1 : 0;
        ls   = base + ofs;
        rs   = (f == 2'b11) ? ls + len : ls + HALF;
        mask = 32'hFFFF_FFFF << (32 - len);
        lm   = lv & mask;
        rm   = rv & mask;
        for (int k = 0; k < n; k++) begin
            if (k >= ls && k < ls + len) begin
                din[k] = lv[31-(k-ls)]; e_sdo[k] = tx[31-(k-ls)]; e_oe[k] = 1'b1;
            end else begin
                din[k] = (k >= rs && k < rs + len) ? rv[31-(k-rs)] : k[0];
                e_sdo[k] = 1'b0; e_oe[k] = !hz;
            end
        end
        vp = -1;
        if (sel == 2'b01) begin
            vp = ls + len - 1; sb_q.push_back(lm);
        end else if (sel == 2'b10) begin
            vp = rs + len - 1; sb_q.push_back(rm);
        end else if (sel == 2'b11) begin
            vp = rs + len - 1;
            s = $signed({lm[31], lm}) + $signed({rm[31], rm});
            sb_q.push_back(s[32:1]);
        end
        err_x = 0; err_t = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk); bclk_rise = 1'b1; frame_start = (k == 0);
            @(negedge clk); bclk_rise = 1'b0; frame_start = 1'b0;
            if (rx_valid != ((k == 0) ? prev_hit : (k - 1 == vp))) err_t++;
            if (k == 0) begin
                fmt = f; wsel = w; start_ofs = 8'(ofs); rx_sel = sel; hiz_en = hz; tx_sample = tx;
            end
            @(negedge clk); bclk_fall = 1'b1;
            @(negedge clk); bclk_fall = 1'b0;
            if (sdo !== e_sdo[k] || sdo_oe !== e_oe[k]) begin
                if (err_x == 0)
                    $display("  slot %0d sdo=%b/%b oe=%b/%b", k, sdo, e_sdo[k], sdo_oe, e_oe[k]);
                err_x++;
            end
            sdi = din[k];
        end
        prev_hit = (vp == n - 1);
        check(err_x == 0, {tag, " R6 tx slots"}, err_x, 0);
        check(err_t == 0, {tag, " R9 valid timing"}, err_t, 0);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int bad;
        repeat (4) @(negedge clk);
        // R1: reset state with tri-state on, then off
        check(sdo == 1'b0 && sdo_oe == 1'b0, "R1 reset sdo/oe hiz", {sdo, sdo_oe}, 0);
        check(rx_valid == 1'b0 && rx_data == 32'd0, "R1 reset rx", rx_data, 0);
        hiz_en = 1'b0;
        @(negedge clk);
        check(sdo_oe == 1'b1, "R1 R6 oe without hiz", sdo_oe, 1);
        hiz_en = 1'b1;
        rst_n = 1'b1;
        // R10: strobes before any frame start do nothing
        bad = 0;
        rx_sel = 2'b11; wsel = 2'b00; tx_sample = 32'hFFFF_FFFF;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); bclk_rise = 1'b1; sdi = 1'b1;
            @(negedge clk); bclk_rise = 1'b0;
            if (rx_valid) bad++;
            @(negedge clk); bclk_fall = 1'b1;
            @(negedge clk); bclk_fall = 1'b0;
            if (sdo_oe || sdo) bad++;
        end
        check(bad == 0, "R10 idle before frame", bad, 0);
        // R2 R3: left-justified 16-bit, capture left
        run_frame(2'b00, 2'b00, 0, 2'b01, 1'b1, 32'hA5C3_9999, 32'h1234_5678, 32'hFFFF_0000, 64, "LJ16");
        // R3: right-justified 20-bit, capture right; last bit lands on next frame's rise 0
        run_frame(2'b01, 2'b01, 0, 2'b10, 1'b1, 32'h8F0F_1234, 32'h0000_0001, 32'hC0FF_EE00, 64, "RJ20");
        // R3 R6: I2S 24-bit, one-slot delay, no tri-state
        run_frame(2'b10, 2'b10, 0, 2'b01, 1'b0, 32'h5A5A_5A00, 32'hDEAD_BEEF, 32'h0, 64, "I2S24");
        // R3 R2: DSP 32-bit, right directly after left
        run_frame(2'b11, 2'b11, 0, 2'b10, 1'b1, 32'hF00D_CAFE, 32'h1111_1111, 32'h8765_4321, 64, "DSP32");
        // R5 R8: left-justified 16-bit at offset 8, averaged capture of negatives
        run_frame(2'b00, 2'b00, 8, 2'b11, 1'b1, 32'h0001_0000, 32'h8000_0000, 32'hFFFF_0000, 64, "OFS8MIX");
        // R5 R8: DSP 24-bit at offset 16, averaged capture
        run_frame(2'b11, 2'b10, 16, 2'b11, 1'b1, 32'h7FFF_FF00, 32'h7FFF_FF00, 32'h0000_0300, 64, "DSPOFS");
        // R8: capture off, no word expected
        run_frame(2'b00, 2'b11, 0, 2'b00, 1'b0, 32'h0F0F_0F0F, 32'hAAAA_AAAA, 32'h5555_5555, 64, "OFF");
        // R4: frame start rewinds even after a short frame
        run_frame(2'b00, 2'b00, 4, 2'b01, 1'b1, 32'hC001_0000, 32'h4321_0000, 32'h0, 24, "SHORT");
        run_frame(2'b00, 2'b00, 0, 2'b00, 1'b1, 32'h0, 32'h0, 32'h0, 8, "FLUSH");
        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R9 all expected words seen", sb_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule